// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block converts a parallel word into a serial bit stream. It has two registers of equal width. A storage register captures the parallel input bus whenever a latch strobe arrives. A shift register takes its parallel load from the storage register. It can also be filled one bit at a time from a serial input.

A mode select chooses what the shift register does. When the select is low, the shift register follows the storage register. When a latch strobe arrives in the same cycle, the bus value goes straight into both registers. When the select is high, each shift strobe moves every stage one place toward the most significant bit, and the serial input enters stage 0.

Only the most significant stage leaves the block. It is presented as a data/enable pair for a three-state driver, with an active-low output enable.

Both strobes are single-cycle enables sampled on one system clock. The shift register decodes, every cycle, one of four named actions:
- HOLD: select high, no shift strobe.
- SHIFT: select high, shift strobe present.
- COPY: select low, no latch strobe.
- DIRECT: select low, latch strobe present.

The action is re-evaluated every cycle, so all transitions between actions are legal.

Top module: `piso_latched_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both the storage register and the shift register become all zeros. `ser_out` therefore reads 0 after reset, and a COPY right after reset also leaves 0.
- R2: A cycle with `latch_stb` high loads `par_in` into the storage register at that edge, whatever `load_n` and `shift_stb` are.
- R3: COPY: with `load_n` low and `latch_stb` low, the shift register takes the storage register's value at the edge.
- R4: DIRECT: with `load_n` low and `latch_stb` high, the shift register takes `par_in` at the same edge at which the storage register captures it.
- R5: SHIFT: with `load_n` high and `shift_stb` high, bit i takes bit i-1 and bit 0 takes `ser_in`. `ser_out` is bit 7 (MSB), so a loaded word leaves MSB first.
- R6: With `load_n` low, `shift_stb` has no effect: the parallel copy takes priority.
- R7: HOLD: with `load_n` high and `shift_stb` low, the shift register keeps its value.
- R8: `ser_out` always shows the shift register's MSB. `ser_oe` is 1 exactly when `oe_n` is 0, with no clock delay (`ser_oe` = 0 means high impedance).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| par_in | input | 8 | Parallel data bus |
| ser_in | input | 1 | Serial data into stage 0 |
| latch_stb | input | 1 | Capture strobe for the storage register |
| shift_stb | input | 1 | Shift strobe |
| load_n | input | 1 | Mode select: 0 = parallel copy, 1 = shift |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Last-stage data |
| ser_oe | output | 1 | Driver enable for `ser_out` |

## Verification
Register updates caused by the strobes and by `load_n` show at `ser_out` one clock edge later. `ser_oe` follows `oe_n` within the same cycle.

The bench drives inputs at the falling edge. It lets one rising edge pass, then samples at the next falling edge. At that point a reference model, advanced by the same inputs, gives the expected MSB and enable.

Full register contents are checked by collecting eight `ser_out` samples across eight SHIFT cycles.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SHIFT  = 2'd1,
        ACT_COPY   = 2'd2,
        ACT_DIRECT = 2'd3
    } act_e;
endpackage

// File: rtl/piso_storage.sv
module piso_storage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_stb,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] store_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (latch_stb)
            store_q <= par_in;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> store_q == $past(par_in));

    p_reset_store_r1: assert property (@(posedge clk)
        !rst_n |=> store_q == '0);
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
    import piso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         latch_stb,
    input  logic         shift_stb,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    input  logic [W-1:0] store_q,
    output logic [W-1:0] sh_q
);
    act_e act;

    // Action decode; the parallel path wins over a shift strobe.
    always_comb begin
        if (!load_n)
            act = latch_stb ? ACT_DIRECT : ACT_COPY;
        else
            act = shift_stb ? ACT_SHIFT : ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            unique case (act)
                ACT_HOLD:   sh_q <= sh_q;
                ACT_SHIFT:  sh_q <= {sh_q[W-2:0], ser_in};
                ACT_COPY:   sh_q <= store_q;
                ACT_DIRECT: sh_q <= par_in;
                default:    sh_q <= sh_q;
            endcase
        end
    end

    p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !latch_stb) |=> sh_q == $past(store_q));

    p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && latch_stb) |=> sh_q == $past(par_in));

    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_stb) |=> sh_q == {$past(sh_q[W-2:0]), $past(ser_in)});

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_stb) |=> $stable(sh_q));

    p_reset_sh_r1: assert property (@(posedge clk)
        !rst_n |=> sh_q == '0);
endmodule

// File: rtl/piso_out_drv.sv
module piso_out_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] sh_q,
    input  logic         oe_n,
    output logic         ser_out,
    output logic         ser_oe
);
    always_comb begin
        ser_out = sh_q[W-1];
        ser_oe  = ~oe_n;
    end

    always_comb begin
        p_oe_r8: assert (ser_oe != oe_n);
    end
endmodule

// File: rtl/piso_latched_shifter.sv
module piso_latched_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    input  logic         latch_stb,
    input  logic         shift_stb,
    input  logic         load_n,
    input  logic         oe_n,
    output logic         ser_out,
    output logic         ser_oe
);
    logic [W-1:0] store_q;
    logic [W-1:0] sh_q;

    piso_storage #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_stb (latch_stb),
        .par_in    (par_in),
        .store_q   (store_q)
    );

    piso_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .latch_stb (latch_stb),
        .shift_stb (shift_stb),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .store_q   (store_q),
        .sh_q      (sh_q)
    );

    piso_out_drv #(.W(W)) u_out (
        .sh_q    (sh_q),
        .oe_n    (oe_n),
        .ser_out (ser_out),
        .ser_oe  (ser_oe)
    );

    // R6: a shift strobe during a parallel copy must not move the data.
    p_load_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && shift_stb && !latch_stb) |=> sh_q == $past(store_q));
endmodule

// File: tb/sim_piso_latched_shifter.sv
module sim_piso_latched_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] par_in = '0;
    logic       ser_in = 1'b0;
    logic       latch_stb = 1'b0;
    logic       shift_stb = 1'b0;
    logic       load_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       ser_out;
    logic       ser_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] m_st = '0;
    logic [7:0] m_sh = '0;

    always #10 clk = ~clk;

    piso_latched_shifter #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
        .latch_stb(latch_stb), .shift_stb(shift_stb), .load_n(load_n),
        .oe_n(oe_n), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    function automatic string req_of(input logic l, input logic s, input logic ld_n);
        if (!ld_n) return l ? "R4" : (s ? "R6" : "R3");
        return s ? "R5" : "R7";
    endfunction

    function automatic logic [7:0] next_sh(input logic [7:0] sh, input logic [7:0] st,
                                           input logic l, input logic s, input logic ld_n,
                                           input logic si, input logic [7:0] d);
        if (!ld_n) return l ? d : st;
        if (s) return {sh[6:0], si};
        return sh;
    endfunction

    task automatic check(input string r, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", r, act, exp);
        end
    endtask

    task automatic check8(input string r, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge act, sample at the next falling edge.
    task automatic step(input logic l, input logic s, input logic ld_n,
                        input logic si, input logic [7:0] d, input logic oe);
        latch_stb = l; shift_stb = s; load_n = ld_n; ser_in = si; par_in = d; oe_n = oe;
        @(posedge clk);
        m_sh = next_sh(m_sh, m_st, l, s, ld_n, si, d);
        if (l) m_st = d; // R2
        @(negedge clk);
        check(req_of(l, s, ld_n), ser_out, m_sh[7]);
        check("R8", ser_oe, ~oe);
    endtask

    task automatic read8(input string r, input logic [7:0] exp);
        logic [7:0] got = '0;
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], ser_out};
            step(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        end
        check8(r, got, exp);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1", ser_out, 1'b0);
        rst_n = 1'b1;
        // R1: COPY straight after reset keeps zero
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0);
        check("R1", ser_out, 1'b0);
        read8("R1", 8'h00);

        // R2 then R3: latch while shifting, then copy
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'hA5, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        read8("R3", 8'hA5);

        // R4: direct load with simultaneous latch
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0);
        read8("R4", 8'h5A);
        // R2: storage kept 5A
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        read8("R2", 8'h5A);

        // R6: shift strobe during copy is ignored
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        read8("R6", 8'hC3);

        // R5: serial fill, then read back MSB first
        for (int i = 7; i >= 0; i--)
            step(1'b0, 1'b1, 1'b1, 1'(8'h3C >> i), 8'h00, 1'b0);
        read8("R5", 8'h3C);

        // R7: hold keeps the word
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0);
        repeat (4) step(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0);
        read8("R7", 8'h96);

        // R8: disable output
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
        check("R8", ser_oe, 1'b0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            step(r[0], r[1], r[2], r[3], r[15:8], r[4] & r[5]);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule